// File: doc/BRIEF.md
# Single-Clock FIFO Controller for an External Two-Port RAM

This block supplies the control logic of a first-in first-out queue whose storage is an external two-port RAM. It keeps a write pointer, a read pointer and an element count, and it drives the write strobe, write address, read strobe and read address of the RAM. Write data goes from the producer straight to the RAM data input, and the controller never touches it. Read data comes back from the RAM, which has one cycle of read latency, and is registered inside the controller. The result reaches the consumer two clocks after the read request, with a single-cycle valid strobe. The same clock times both sides of the queue.

An occupancy state machine has three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. Its transitions are named as follows. *First-fill* moves from `OCC_EMPTY` to `OCC_PARTIAL`, or straight to `OCC_FULL` when the depth is one. *Top-off* moves from `OCC_PARTIAL` to `OCC_FULL`. *Drain-out* moves from `OCC_PARTIAL` to `OCC_EMPTY`. *Release* moves from `OCC_FULL` to `OCC_PARTIAL`. *Dump* moves from `OCC_FULL` to `OCC_EMPTY` when the depth is one. Every other cycle is a *hold* in the current state. The full and empty outputs decode this state register. The almost-full and almost-empty outputs are registered comparisons of the next count against thresholds. Each threshold comes either from a parameter or from an input bus, and the choice is made separately for each one.

Two optional modes change what happens at the limits of the queue. In overwrite mode, a write to a full queue is accepted, and if no read is accepted in the same cycle it evicts the oldest entry. In read-when-empty mode, a read of an empty queue fetches the RAM word at the read pointer and leaves all state as it was.

Top module: `fifo_ram_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous), `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `wr_ack`=0, `overflow`=0, `underflow`=0, `rd_valid`=0 and `rd_data`=0, and both pointers are 0.
- R2: `full` rises at the clock edge that accepts the write which makes the count equal to DEPTH. `empty` rises at the edge that accepts the read which takes the count to 0. Neither flag changes at any other edge.
- R3: After every edge, `almost_full` is 1 exactly when the count is greater than or equal to the almost-full threshold (threshold at least 1).
- R4: After every edge, `almost_empty` is 1 exactly when the count is less than or equal to the almost-empty threshold.
- R5: With `AF_DYNAMIC`/`AE_DYNAMIC` at 0 the thresholds are `AF_LEVEL`/`AE_LEVEL`, and `af_level`/`ae_level` have no effect on the flags. With the parameter at 1 the bus value sampled at each edge is used.
- R6: A write is accepted when `wr_en`=1 and either `full`=0 or overwrite mode is on. An accepted write drives `ram_we`=1 in that cycle, with `ram_waddr` equal to the write pointer, and `wr_ack`=1 for one cycle after the edge.
- R7: In normal mode, `wr_en`=1 while `full`=1 gives no `ram_we` and raises `overflow` for the one cycle after that edge, once per rejected write.
- R8: In normal mode, `rd_en`=1 while `empty`=1 gives no `ram_re`, leaves the read pointer unchanged, and raises `underflow` for the one cycle after that edge, once per rejected read.
- R9: A RAM read issued at edge N puts the RAM word on `rd_data` after edge N+1, with `rd_valid`=1 for that single cycle. `rd_data` then holds until the next read result.
- R10: A cycle with both a write and a read accepted leaves the count, and so all four flags at fixed thresholds, unchanged.
- R11: In overwrite mode, a write while full is accepted with `wr_ack` and no `overflow`. With no read in the same cycle, the read pointer also advances, so the oldest entry is lost and the queue stays full.
- R12: In read-when-empty mode, a read while empty drives `ram_re` at the unchanged read pointer, produces a `rd_valid` pulse two clocks later, and gives no `underflow` and no change to the pointers or flags.
- R13: Both pointers count 0 to DEPTH-1 and wrap to 0, for power-of-two and other depths alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| af_level | input | CW | Run-time almost-full threshold |
| ae_level | input | CW | Run-time almost-empty threshold |
| ram_rdata | input | WIDTH | RAM read port data, one cycle after `ram_re` |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | AW | RAM write address |
| ram_re | output | 1 | RAM read strobe |
| ram_raddr | output | AW | RAM read address |
| rd_data | output | WIDTH | Registered read data |
| rd_valid | output | 1 | One-cycle strobe marking new `rd_data` |
| wr_ack | output | 1 | Accepted-write pulse |
| overflow | output | 1 | Rejected-write pulse |
| underflow | output | 1 | Rejected-read pulse |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| almost_full | output | 1 | Count at or above the almost-full threshold |
| almost_empty | output | 1 | Count at or below the almost-empty threshold |

## Verification
A count that has drifted from the true occupancy shows at the ports within one edge. The almost flags are compared against the count at every edge, so a sweep of both thresholds across all levels exposes a single-step count error the next time the count moves past any threshold. A pointer that skips an address, or wraps at the wrong place, shows up as a wrong `ram_waddr` or `ram_raddr` in the same cycle as the strobe. Two cycles later it also returns the wrong data word on `rd_data`. A fault in the state register shows as a `full` or `empty` that disagrees with the count, and one edge later as a wrongly rejected or wrongly accepted access, flagged by `overflow`, `underflow` or a missing `wr_ack`.

// File: rtl/fifo_ctrl_pkg.sv
package fifo_ctrl_pkg;

    // Occupancy states of the queue
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // Address width for a given depth (at least one bit)
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Count width able to hold 0..depth
    function automatic int unsigned count_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam bit            POW2  = ((1 << AW) == DEPTH);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_inc;

    generate
        if (POW2) begin : g_pow2
            // natural binary wrap at 2**AW
            assign ptr_inc = ptr_q + AW'(1);
        end else begin : g_mod
            // explicit wrap at DEPTH-1
            assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= ptr_inc;
        end
    end

    assign ptr = ptr_q;

    // R13: pointer never leaves 0..DEPTH-1
    a_r13_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

    // R13: advancing from the last slot lands on slot zero
    a_r13_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr_q == LAST) |=> (ptr_q == '0));

    // R8: pointer holds when not advanced
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));

endmodule

// File: rtl/fifo_occ_fsm.sv
module fifo_occ_fsm
    import fifo_ctrl_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic [CW-1:0] af_thr,
    input  logic [CW-1:0] ae_thr,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    occ_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          af_q, ae_q;

    // next element count
    always_comb begin
        unique case ({inc, dec})
            2'b10:   cnt_d = cnt_q + CW'(1);
            2'b01:   cnt_d = cnt_q - CW'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    // next occupancy state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: begin
                // first-fill
                if (cnt_d != '0) begin
                    st_d = (cnt_d == DEPTH_C) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (cnt_d == DEPTH_C) begin
                    st_d = OCC_FULL;      // top-off
                end else if (cnt_d == '0) begin
                    st_d = OCC_EMPTY;     // drain-out
                end
            end
            OCC_FULL: begin
                if (cnt_d != DEPTH_C) begin
                    // release, or dump for a depth of one
                    st_d = (cnt_d == '0) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: st_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= OCC_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // registered count and threshold flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            af_q  <= 1'b0;
            ae_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            af_q  <= (cnt_d >= af_thr);
            ae_q  <= (cnt_d <= ae_thr);
        end
    end

    assign full         = (st_q == OCC_FULL);
    assign empty        = (st_q == OCC_EMPTY);
    assign almost_full  = af_q;
    assign almost_empty = ae_q;

    // R2: state register agrees with the count register
    a_r2_full_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        full == (cnt_q == DEPTH_C));

    a_r2_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (cnt_q == '0));

    // R2: no growth past full, no shrink below empty
    a_r2_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && inc && !dec));

    a_r2_no_underdrain: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && dec && !inc));

    // R10: balanced cycle keeps the count
    a_r10_balanced_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));

endmodule

// File: rtl/fifo_rd_pipe.sv
module fifo_rd_pipe #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);

    logic             issue_d1;
    logic             valid_q;
    logic [WIDTH-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_d1 <= 1'b0;
            valid_q  <= 1'b0;
            data_q   <= '0;
        end else begin
            issue_d1 <= issue;
            valid_q  <= issue_d1;
            if (issue_d1) begin
                data_q <= ram_rdata;
            end
        end
    end

    assign rd_data  = data_q;
    assign rd_valid = valid_q;

    // R9: result is flagged two edges after the RAM read
    a_r9_valid_two_later: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> ##1 valid_q);

    // R9: data holds when no new result arrives
    a_r9_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(data_q));

endmodule

// File: rtl/fifo_ram_ctrl.sv
module fifo_ram_ctrl
    import fifo_ctrl_pkg::*;
#(
    parameter int unsigned DEPTH            = 16,
    parameter int unsigned WIDTH            = 8,
    parameter bit          AF_DYNAMIC       = 1'b0,
    parameter bit          AE_DYNAMIC       = 1'b0,
    parameter int unsigned AF_LEVEL         = 12,
    parameter int unsigned AE_LEVEL         = 4,
    parameter bit          ALLOW_OVERWRITE  = 1'b0,
    parameter bit          ALLOW_READ_EMPTY = 1'b0,
    localparam int unsigned AW = addr_bits(DEPTH),
    localparam int unsigned CW = count_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CW-1:0]    af_level,
    input  logic [CW-1:0]    ae_level,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic             ram_re,
    output logic [AW-1:0]    ram_raddr,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             wr_ack,
    output logic             overflow,
    output logic             underflow,
    output logic             full,
    output logic             empty,
    output logic             almost_full,
    output logic             almost_empty
);

    logic          rd_take;     // read that removes an element
    logic          rd_peek;     // read of an empty queue in read-when-empty mode
    logic          wr_take;     // accepted write
    logic          wr_evict;    // overwrite that drops the oldest element
    logic          rd_adv;
    logic [CW-1:0] af_thr, ae_thr;
    logic [AW-1:0] wptr, rptr;
    logic          ack_q, ovf_q, udf_q;

    // access decisions
    always_comb begin
        rd_take  = rd_en && !empty;
        rd_peek  = rd_en && empty && ALLOW_READ_EMPTY;
        wr_take  = wr_en && (!full || ALLOW_OVERWRITE);
        wr_evict = wr_take && full && !rd_take;
        rd_adv   = rd_take || wr_evict;
    end

    // threshold source per parameter
    assign af_thr = AF_DYNAMIC ? af_level : CW'(AF_LEVEL);
    assign ae_thr = AE_DYNAMIC ? ae_level : CW'(AE_LEVEL);

    fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (wr_take),
        .ptr   (wptr)
    );

    fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rd_adv),
        .ptr   (rptr)
    );

    fifo_occ_fsm #(.DEPTH(DEPTH), .CW(CW)) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc          (wr_take && !wr_evict),
        .dec          (rd_take),
        .af_thr       (af_thr),
        .ae_thr       (ae_thr),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    fifo_rd_pipe #(.WIDTH(WIDTH)) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (ram_re),
        .ram_rdata (ram_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // RAM control
    assign ram_we    = wr_take;
    assign ram_waddr = wptr;
    assign ram_re    = rd_take || rd_peek;
    assign ram_raddr = rptr;

    // access result pulses, one cycle after the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ack_q <= wr_take;
            ovf_q <= wr_en && !wr_take;
            udf_q <= rd_en && empty && !ALLOW_READ_EMPTY;
        end
    end

    assign wr_ack    = ack_q;
    assign overflow  = ovf_q;
    assign underflow = udf_q;

    // R6: every RAM write is acknowledged next cycle
    a_r6_ack_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> wr_ack);

    // R7: a full queue in normal mode blocks the RAM write and flags it
    a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ALLOW_OVERWRITE) |-> !ram_we);

    a_r7_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !ALLOW_OVERWRITE) |=> overflow);

    // R8: an empty queue in normal mode blocks the RAM read and flags it
    a_r8_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !ALLOW_READ_EMPTY) |-> !ram_re);

    a_r8_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !ALLOW_READ_EMPTY) |=> underflow);

    // R11: overwrite mode never reports overflow
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ALLOW_OVERWRITE |-> !overflow);

    // R12: read-when-empty mode never reports underflow
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        ALLOW_READ_EMPTY |-> !underflow);

endmodule

// File: tb/fifo_ram_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_ram_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // instance 0: depth 5, run-time thresholds, normal mode
    logic       weA_in, reA_in;
    logic [2:0] afA, aeA;
    logic [7:0] rdA, wdA, qA;
    logic       weA, reA, dvA, ackA, ovfA, udfA, fullA, emptyA, alfA, aleA;
    logic [2:0] waA, raA;

    // instance 1: depth 4, fixed thresholds 3/1, overwrite and read-when-empty
    logic       weB_in, reB_in;
    logic [2:0] afB, aeB;
    logic [7:0] rdB, wdB, qB;
    logic       weB, reB, dvB, ackB, ovfB, udfB, fullB, emptyB, alfB, aleB;
    logic [1:0] waB, raB;

    fifo_ram_ctrl #(
        .DEPTH(5), .WIDTH(8), .AF_DYNAMIC(1'b1), .AE_DYNAMIC(1'b1),
        .AF_LEVEL(4), .AE_LEVEL(1), .ALLOW_OVERWRITE(1'b0), .ALLOW_READ_EMPTY(1'b0)
    ) u_fifo_ram_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(weA_in), .rd_en(reA_in),
        .af_level(afA), .ae_level(aeA), .ram_rdata(rdA),
        .ram_we(weA), .ram_waddr(waA), .ram_re(reA), .ram_raddr(raA),
        .rd_data(qA), .rd_valid(dvA), .wr_ack(ackA), .overflow(ovfA),
        .underflow(udfA), .full(fullA), .empty(emptyA),
        .almost_full(alfA), .almost_empty(aleA)
    );

    fifo_ram_ctrl #(
        .DEPTH(4), .WIDTH(8), .AF_DYNAMIC(1'b0), .AE_DYNAMIC(1'b0),
        .AF_LEVEL(3), .AE_LEVEL(1), .ALLOW_OVERWRITE(1'b1), .ALLOW_READ_EMPTY(1'b1)
    ) u_ovw (
        .clk(clk), .rst_n(rst_n), .wr_en(weB_in), .rd_en(reB_in),
        .af_level(afB), .ae_level(aeB), .ram_rdata(rdB),
        .ram_we(weB), .ram_waddr(waB), .ram_re(reB), .ram_raddr(raB),
        .rd_data(qB), .rd_valid(dvB), .wr_ack(ackB), .overflow(ovfB),
        .underflow(udfB), .full(fullB), .empty(emptyB),
        .almost_full(alfB), .almost_empty(aleB)
    );

    // behavioural RAMs, one-cycle synchronous read, read before write
    logic [7:0] memA [8];
    logic [7:0] memB [4];
    always @(posedge clk) begin
        if (weA) memA[waA] <= wdA;
        if (reA) rdA <= memA[raA];
        if (weB) memB[waB] <= wdB;
        if (reB) rdB <= memB[raB];
    end

    // reference model state
    int         m_cnt [2], m_wp [2], m_rp [2], m_dep [2];
    bit         m_ovw [2], m_rde [2];
    logic [7:0] m_mem [2][8];
    bit         e_full [2], e_empty [2], e_af [2], e_ae [2];
    bit         e_ack [2], e_ovf [2], e_udf [2], e_dv [2], p_iss [2];
    logic [7:0] e_q [2], p_dat [2];

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string ph = "";

    task automatic check(input string tag, input int i, input string nm,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s inst%0d %s: actual %0d expected %0d at %0t",
                     tag, i, nm, act, exp, $time);
        end
    endtask

    // registered outputs against the model
    task automatic check_regs();
        string t2;
        t2 = (ph != "") ? ph : "R2";
        check(t2,    0, "full",         fullA,  e_full[0]);
        check(t2,    0, "empty",        emptyA, e_empty[0]);
        check("R3",  0, "almost_full",  alfA,   e_af[0]);
        check("R4",  0, "almost_empty", aleA,   e_ae[0]);
        check("R6",  0, "wr_ack",       ackA,   e_ack[0]);
        check("R7",  0, "overflow",     ovfA,   e_ovf[0]);
        check("R8",  0, "underflow",    udfA,   e_udf[0]);
        check("R9",  0, "rd_valid",     dvA,    e_dv[0]);
        check("R9",  0, "rd_data",      qA,     e_q[0]);
        check("R11", 1, "full",         fullB,  e_full[1]);
        check("R12", 1, "empty",        emptyB, e_empty[1]);
        check("R5",  1, "almost_full",  alfB,   e_af[1]);
        check("R5",  1, "almost_empty", aleB,   e_ae[1]);
        check("R11", 1, "wr_ack",       ackB,   e_ack[1]);
        check("R11", 1, "overflow",     ovfB,   e_ovf[1]);
        check("R12", 1, "underflow",    udfB,   e_udf[1]);
        check("R12", 1, "rd_valid",     dvB,    e_dv[1]);
        check("R12", 1, "rd_data",      qB,     e_q[1]);
    endtask

    // model one instance across one edge and check its RAM strobes
    task automatic model(input int i, input bit we, input bit re,
                         input int aft, input int aet, input logic [7:0] wd);
        bit   full_n, empty_n, rd_take, rd_peek, wr_take, evict;
        int   a_we, a_re, a_wa, a_ra;
        logic [7:0] rv;
        full_n  = (m_cnt[i] == m_dep[i]);
        empty_n = (m_cnt[i] == 0);
        rd_take = re && !empty_n;
        rd_peek = re && empty_n && m_rde[i];
        wr_take = we && (!full_n || m_ovw[i]);
        evict   = wr_take && full_n && !rd_take;
        if (i == 0) begin
            a_we = weA; a_re = reA; a_wa = waA; a_ra = raA;
        end else begin
            a_we = weB; a_re = reB; a_wa = waB; a_ra = raB;
        end
        check((i == 0) ? "R7" : "R11", i, "ram_we", a_we, wr_take);
        check((i == 0) ? "R8" : "R12", i, "ram_re", a_re, rd_take || rd_peek);
        if (wr_take) check((i == 0) ? "R13" : "R6", i, "ram_waddr", a_wa, m_wp[i]);
        if (rd_take || rd_peek) check((i == 0) ? "R13" : "R12", i, "ram_raddr", a_ra, m_rp[i]);
        rv = m_mem[i][m_rp[i]];
        e_dv[i] = p_iss[i];
        if (p_iss[i]) e_q[i] = p_dat[i];
        p_iss[i] = rd_take || rd_peek;
        p_dat[i] = rv;
        if (wr_take) begin
            m_mem[i][m_wp[i]] = wd;
            m_wp[i] = (m_wp[i] + 1) % m_dep[i];
        end
        if (rd_take || evict) m_rp[i] = (m_rp[i] + 1) % m_dep[i];
        m_cnt[i] = m_cnt[i] + ((wr_take && !evict) ? 1 : 0) - (rd_take ? 1 : 0);
        e_ack[i]   = wr_take;
        e_ovf[i]   = we && !wr_take;
        e_udf[i]   = re && empty_n && !m_rde[i];
        e_full[i]  = (m_cnt[i] == m_dep[i]);
        e_empty[i] = (m_cnt[i] == 0);
        e_af[i]    = (m_cnt[i] >= aft);
        e_ae[i]    = (m_cnt[i] <= aet);
    endtask

    int seq = 0;
    // one clock: check outputs, drive inputs, model the edge
    task automatic step(input bit wa, input bit ra, input bit wb, input bit rb);
        check_regs();
        seq++;
        weA_in = wa; reA_in = ra; weB_in = wb; reB_in = rb;
        wdA = 8'(seq); wdB = 8'(seq) ^ 8'h5A;
        #1;
        model(0, wa, ra, int'(afA), int'(aeA), wdA);
        model(1, wb, rb, 3, 1, wdB);
        @(negedge clk);
    endtask

    logic [15:0] lf = 16'hACE1;
    task automatic lfsr_next();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        weA_in = 0; reA_in = 0; weB_in = 0; reB_in = 0;
        afA = 3'd4; aeA = 3'd1; afB = 3'd0; aeB = 3'd7; wdA = 0; wdB = 0;
        for (int k = 0; k < 8; k++) memA[k] = 8'h00;
        for (int k = 0; k < 4; k++) memB[k] = 8'h00;
        m_dep[0] = 5; m_dep[1] = 4; m_ovw[0] = 0; m_ovw[1] = 1; m_rde[0] = 0; m_rde[1] = 1;
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_wp[i] = 0; m_rp[i] = 0;
            e_full[i] = 0; e_empty[i] = 1; e_af[i] = 0; e_ae[i] = 1;
            e_ack[i] = 0; e_ovf[i] = 0; e_udf[i] = 0; e_dv[i] = 0; p_iss[i] = 0;
            e_q[i] = 8'h00; p_dat[i] = 8'h00;
            for (int k = 0; k < 8; k++) m_mem[i][k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        check("R1", 0, "empty", emptyA, 1);  check("R1", 0, "full", fullA, 0);
        check("R1", 0, "almost_empty", aleA, 1); check("R1", 0, "almost_full", alfA, 0);
        check("R1", 0, "rd_valid", dvA, 0);  check("R1", 0, "rd_data", qA, 0);
        check("R1", 0, "ram_waddr", waA, 0); check("R1", 0, "ram_raddr", raA, 0);
        check("R1", 1, "empty", emptyB, 1);  check("R1", 1, "overflow", ovfB, 0);
        rst_n = 1'b1;

        // threshold sweep: fill past full then drain past empty, every threshold pair
        for (int af = 1; af <= 5; af++) begin
            for (int ae = 0; ae <= 4; ae++) begin
                afA = 3'(af); aeA = 3'(ae); afB = 3'(ae); aeB = 3'(af);
                for (int k = 0; k < 6; k++) step(1, 0, 1, 0);
                for (int k = 0; k < 6; k++) step(0, 1, 0, 1);
            end
        end

        // R10: balanced traffic keeps the count
        ph = "R10";
        afA = 3'd2; aeA = 3'd2;
        step(1, 0, 1, 0); step(1, 0, 1, 0);
        for (int k = 0; k < 4; k++) step(1, 1, 1, 1);
        for (int k = 0; k < 3; k++) step(0, 1, 0, 1);
        ph = "";

        // pseudo-random traffic in three biases, thresholds moving
        for (int n = 0; n < 3000; n++) begin
            bit w, r;
            lfsr_next();
            if (n % 64 == 0) begin
                afA = 3'(1 + (lf[7:5] % 5));
                aeA = 3'(lf[10:8] % 5);
            end
            afB = lf[13:11]; aeB = lf[4:2];
            if (n < 1000)      begin w = lf[0] | lf[1]; r = lf[3];          end
            else if (n < 2000) begin w = lf[0];         r = lf[3] | lf[4];  end
            else               begin w = lf[0];         r = lf[3];          end
            step(w, r, r ^ lf[6], w ^ lf[9]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule